// File: doc/BRIEF.md
# Serial Command and Operand Loader for a Modular Exponentiation Engine

This block is the serial front end that sits in front of a modular exponentiation core. It listens on one asynchronous receive line for frames made of a low start bit, eight data bits sent least significant bit first, an odd parity bit and a high stop bit. Bytes that arrive while the block waits for a command are decoded as opcodes. Four of the opcodes choose one of four wide operand registers (base, modulus, exponent, residue). The data bytes that follow are shifted into the chosen register.

A run opcode sends a one-cycle start pulse to the arithmetic core. The block then ignores the line until the core reports completion, and at that point it captures the core's result. A read opcode sends the captured result back on the transmit line, one byte at a time, in the same frame format. A frame with bad parity or a low stop bit is discarded and sets a sticky error flag. A dedicated opcode clears that flag.

The bit time is derived from the clock and baud parameters (434 clocks at 50 MHz and 115200 baud). Each received bit is sampled at the middle of its bit time.

Top module: `mfe_serial_frontend`

## Requirements
- R1: A received frame is one low start bit, eight data bits sent LSB first, one parity bit and one high stop bit. Each bit lasts CLK_HZ/BAUD clocks (rounded) and is sampled near its midpoint. The line idles high.
- R2: Parity is odd: the eight data bits plus the parity bit must contain an odd number of ones (0x00 carries parity 1, 0x01 carries parity 0). A frame that breaks this rule is dropped and sets frame_err_o.
- R3: A frame whose stop bit is sampled low is dropped and sets frame_err_o.
- R4: In command wait, opcode 0x00 selects the base, 0x01 the modulus, 0x02 the exponent and 0x03 the residue. Each accepted data byte that follows enters the selected register at bits [W-1:W-8] and moves the rest of that register down by one byte. After a full load, the first byte sits in bits 7:0. The other three registers do not change.
- R5: Exactly W/8 accepted data bytes follow a load opcode. Within them any value, including opcode values, is data. The byte after the last one is decoded as an opcode again.
- R6: Opcode 0x04 raises core_start_o for exactly one clock. Every received byte is then ignored until core_done_i is high, and the core_result_i present in that cycle is captured.
- R7: Opcode 0x05 sends the captured result on tx_o as W/8 frames, least significant byte first, in the R1 format with odd parity. Received bytes are ignored until the last frame ends. A later read sends the same bytes again.
- R8: Opcode 0x07 clears frame_err_o. Every other byte value received in command wait (0x06, 0x08 to 0xFF) has no effect, and the block stays in command wait.
- R9: frame_err_o stays set until opcode 0x07 or reset. A dropped frame does not count toward a load.
- R10: During and after reset, all operand outputs are zero, frame_err_o and core_start_o are low, and tx_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial receive line, idles high |
| tx_o | output | 1 | Serial transmit line, idles high |
| base_o | output | OPERAND_W | Base operand register |
| modulus_o | output | OPERAND_W | Modulus operand register |
| exponent_o | output | OPERAND_W | Exponent operand register |
| residue_o | output | OPERAND_W | Residue operand register |
| core_start_o | output | 1 | One-cycle request to the arithmetic core |
| core_done_i | input | 1 | Completion strobe from the arithmetic core |
| core_result_i | input | OPERAND_W | Result from the arithmetic core, valid with core_done_i |
| frame_err_o | output | 1 | Sticky flag for dropped frames |

## Verification
The bench sets CLK_HZ to 1843200 and BAUD to 115200, which gives a 16-clock bit time, and sets OPERAND_W to 32, so each load or readout is four bytes. With these values a complete load, a compute round through a stub core and two readouts fit in a few thousand cycles. The values are still large enough to show byte ordering, to show a corrupted byte being dropped in the middle of a load, and to send bytes while the block is busy or transmitting. The shift and count logic does not depend on width, so the 512-bit default uses the same paths, only with more bytes.

// File: rtl/mfe_pkg.sv
`timescale 1ns/1ps
package mfe_pkg;
   localparam int NUM_OPERANDS = 4;
   localparam int FRAME_BITS   = 11;

   localparam logic [7:0] OPC_LOAD_BASE = 8'h00;
   localparam logic [7:0] OPC_LOAD_MOD  = 8'h01;
   localparam logic [7:0] OPC_LOAD_EXP  = 8'h02;
   localparam logic [7:0] OPC_LOAD_RES  = 8'h03;
   localparam logic [7:0] OPC_RUN       = 8'h04;
   localparam logic [7:0] OPC_READOUT   = 8'h05;
   localparam logic [7:0] OPC_REARM     = 8'h07;

   typedef enum logic [1:0] {
      CS_CMD,
      CS_LOAD,
      CS_BUSY,
      CS_SEND
   } ctrl_state_e;

   typedef enum logic [2:0] {
      RS_IDLE,
      RS_START,
      RS_DATA,
      RS_PAR,
      RS_STOP
   } rx_state_e;

   function automatic logic odd_parity(input logic [7:0] d);
      return ~^d;
   endfunction
endpackage

// File: rtl/mfe_uart_rx.sv
`timescale 1ns/1ps
module mfe_uart_rx
   import mfe_pkg::*;
#(
   parameter int CLKS_PER_BIT = 434,
   parameter int SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_i,
   output logic [7:0] byte_o,
   output logic       byte_valid_o,
   output logic       frame_bad_o
);
   localparam int CW   = $clog2(CLKS_PER_BIT);
   localparam int HALF = CLKS_PER_BIT / 2;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("mfe_uart_rx: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   rx_s;

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= 1'b1;
            else if (s == 0) sync_q[s] <= rx_i;
            else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate
   assign rx_s = sync_q[SYNC_STAGES-1];

   rx_state_e st;
   logic [CW-1:0] cnt;
   logic [2:0]    bidx;
   logic [7:0]    sh;
   logic          par;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= RS_IDLE;
         cnt          <= '0;
         bidx         <= '0;
         sh           <= '0;
         par          <= 1'b0;
         byte_valid_o <= 1'b0;
         frame_bad_o  <= 1'b0;
      end else begin
         byte_valid_o <= 1'b0;
         frame_bad_o  <= 1'b0;
         case (st)
            RS_IDLE: begin
               cnt <= '0;
               if (!rx_s) st <= RS_START;
            end
            RS_START: begin
               if (cnt == CW'(HALF-1)) begin
                  cnt  <= '0;
                  bidx <= '0;
                  st   <= rx_s ? RS_IDLE : RS_DATA;
               end else cnt <= cnt + 1'b1;
            end
            RS_DATA: begin
               if (cnt == CW'(CLKS_PER_BIT-1)) begin
                  cnt  <= '0;
                  sh   <= {rx_s, sh[7:1]};
                  bidx <= bidx + 1'b1;
                  if (bidx == 3'd7) st <= RS_PAR;
               end else cnt <= cnt + 1'b1;
            end
            RS_PAR: begin
               if (cnt == CW'(CLKS_PER_BIT-1)) begin
                  cnt <= '0;
                  par <= rx_s;
                  st  <= RS_STOP;
               end else cnt <= cnt + 1'b1;
            end
            RS_STOP: begin
               if (cnt == CW'(CLKS_PER_BIT-1)) begin
                  cnt <= '0;
                  st  <= RS_IDLE;
                  if (rx_s && (^{sh, par})) byte_valid_o <= 1'b1;
                  else frame_bad_o <= 1'b1;
               end else cnt <= cnt + 1'b1;
            end
            default: st <= RS_IDLE;
         endcase
      end
   end

   assign byte_o = sh;

   // R2 R3: a frame ends as either accepted or dropped, never both
   a_r2_valid_or_bad: assert property (@(posedge clk) disable iff (!rst_n)
      !(byte_valid_o && frame_bad_o));
   // R1: a result is reported only on leaving the stop bit
   a_r1_result_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid_o || frame_bad_o) |-> st == RS_IDLE);
endmodule

// File: rtl/mfe_uart_tx.sv
`timescale 1ns/1ps
module mfe_uart_tx
   import mfe_pkg::*;
#(
   parameter int CLKS_PER_BIT = 434
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] data_i,
   input  logic       send_i,
   output logic       busy_o,
   output logic       tx_o
);
   localparam int CW = $clog2(CLKS_PER_BIT);
   localparam int LW = $clog2(FRAME_BITS);

   logic [FRAME_BITS-1:0] frm;
   logic [CW-1:0]         cnt;
   logic [LW-1:0]         left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         frm    <= '1;
         cnt    <= '0;
         left   <= '0;
      end else if (!busy_o) begin
         if (send_i) begin
            frm    <= {1'b1, odd_parity(data_i), data_i, 1'b0};
            busy_o <= 1'b1;
            cnt    <= '0;
            left   <= LW'(FRAME_BITS-1);
         end
      end else if (cnt == CW'(CLKS_PER_BIT-1)) begin
         cnt <= '0;
         frm <= {1'b1, frm[FRAME_BITS-1:1]};
         if (left == '0) busy_o <= 1'b0;
         else left <= left - 1'b1;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign tx_o = frm[0];

   // R10 (idle line level): the line is high whenever no frame is in flight
   a_r10_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> tx_o);
   // R7: the last bit of every frame is a high stop bit
   a_r7_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && left == '0) |-> tx_o);
   // R7: every frame begins with a low start bit
   a_r7_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> !tx_o);
endmodule

// File: rtl/mfe_cmd_ctrl.sv
`timescale 1ns/1ps
module mfe_cmd_ctrl
   import mfe_pkg::*;
#(
   parameter int OPERAND_W = 512
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic [7:0]                               rx_byte_i,
   input  logic                                     rx_valid_i,
   input  logic                                     rx_bad_i,
   output logic [NUM_OPERANDS-1:0][OPERAND_W-1:0]  opr_o,
   output logic                                     core_start_o,
   input  logic                                     core_done_i,
   input  logic [OPERAND_W-1:0]                     core_result_i,
   output logic [7:0]                               tx_data_o,
   output logic                                     tx_send_o,
   input  logic                                     tx_busy_i,
   output logic                                     err_o
);
   localparam int BYTES = OPERAND_W / 8;
   localparam int BCW   = $clog2(BYTES);
   localparam int IW    = $clog2(BYTES + 1);

   generate
      if ((OPERAND_W % 8) != 0 || BYTES < 2) begin : g_bad_width
         $error("mfe_cmd_ctrl: OPERAND_W must be a multiple of 8 and at least 16");
      end
   endgenerate

   ctrl_state_e          st;
   logic [1:0]           slot;
   logic [BCW-1:0]       bcnt;
   logic [IW-1:0]        idx;
   logic [OPERAND_W-1:0] res_q;
   logic                 rearm;

   assign rearm = (st == CS_CMD) && rx_valid_i && (rx_byte_i == OPC_REARM);

   generate
      for (genvar i = 0; i < NUM_OPERANDS; i++) begin : g_opr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) opr_o[i] <= '0;
            else if (st == CS_LOAD && rx_valid_i && slot == 2'(i))
               opr_o[i] <= {rx_byte_i, opr_o[i][OPERAND_W-1:8]};
         end
         // R4: registers that are not the load target hold their value
         a_r4_others_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (st == CS_LOAD && slot != 2'(i)) |=> $stable(opr_o[i]));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= CS_CMD;
         slot         <= '0;
         bcnt         <= '0;
         idx          <= '0;
         res_q        <= '0;
         core_start_o <= 1'b0;
         tx_send_o    <= 1'b0;
         tx_data_o    <= '0;
         err_o        <= 1'b0;
      end else begin
         core_start_o <= 1'b0;
         tx_send_o    <= 1'b0;
         if (rx_bad_i) err_o <= 1'b1;
         else if (rearm) err_o <= 1'b0;
         case (st)
            CS_CMD: begin
               if (rx_valid_i) begin
                  case (rx_byte_i)
                     OPC_LOAD_BASE, OPC_LOAD_MOD, OPC_LOAD_EXP, OPC_LOAD_RES: begin
                        slot <= rx_byte_i[1:0];
                        bcnt <= '0;
                        st   <= CS_LOAD;
                     end
                     OPC_RUN: begin
                        core_start_o <= 1'b1;
                        st           <= CS_BUSY;
                     end
                     OPC_READOUT: begin
                        idx <= '0;
                        st  <= CS_SEND;
                     end
                     default: ;
                  endcase
               end
            end
            CS_LOAD: begin
               if (rx_valid_i) begin
                  if (bcnt == BCW'(BYTES-1)) st <= CS_CMD;
                  else bcnt <= bcnt + 1'b1;
               end
            end
            CS_BUSY: begin
               if (core_done_i) begin
                  res_q <= core_result_i;
                  st    <= CS_CMD;
               end
            end
            CS_SEND: begin
               if (!tx_busy_i && !tx_send_o) begin
                  if (idx == IW'(BYTES)) st <= CS_CMD;
                  else begin
                     tx_data_o <= res_q[7:0];
                     tx_send_o <= 1'b1;
                     res_q     <= {res_q[7:0], res_q[OPERAND_W-1:8]};
                     idx       <= idx + 1'b1;
                  end
               end
            end
            default: st <= CS_CMD;
         endcase
      end
   end

   // R6: the start request lasts exactly one clock
   a_r6_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      core_start_o |=> !core_start_o);
   // R6: a start request always leaves the block waiting on the core
   a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      core_start_o |-> st == CS_BUSY);
   // R2 R3: a dropped frame raises the error flag on the next clock
   a_r2_bad_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
      rx_bad_i |=> err_o);
   // R9: the error flag only falls through the clearing opcode
   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !rearm) |=> err_o);
   // R7: no new byte is handed to the transmitter while one is in flight
   a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      tx_send_o |-> !tx_busy_i);
endmodule

// File: rtl/mfe_serial_frontend.sv
`timescale 1ns/1ps
module mfe_serial_frontend
   import mfe_pkg::*;
#(
   parameter int CLK_HZ      = 50_000_000,
   parameter int BAUD        = 115_200,
   parameter int OPERAND_W   = 512,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_i,
   output logic                 tx_o,
   output logic [OPERAND_W-1:0] base_o,
   output logic [OPERAND_W-1:0] modulus_o,
   output logic [OPERAND_W-1:0] exponent_o,
   output logic [OPERAND_W-1:0] residue_o,
   output logic                 core_start_o,
   input  logic                 core_done_i,
   input  logic [OPERAND_W-1:0] core_result_i,
   output logic                 frame_err_o
);
   localparam int CLKS_PER_BIT = (CLK_HZ + BAUD/2) / BAUD;

   generate
      if (CLKS_PER_BIT < 4) begin : g_bad_baud
         $error("mfe_serial_frontend: CLK_HZ/BAUD must give at least 4 clocks per bit");
      end
   endgenerate

   logic [7:0] rx_byte;
   logic       rx_valid, rx_bad;
   logic [7:0] tx_data;
   logic       tx_send, tx_busy;
   logic [NUM_OPERANDS-1:0][OPERAND_W-1:0] opr;

   mfe_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .rx_i(rx_i),
      .byte_o(rx_byte), .byte_valid_o(rx_valid), .frame_bad_o(rx_bad)
   );

   mfe_cmd_ctrl #(.OPERAND_W(OPERAND_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .rx_byte_i(rx_byte), .rx_valid_i(rx_valid), .rx_bad_i(rx_bad),
      .opr_o(opr),
      .core_start_o(core_start_o), .core_done_i(core_done_i),
      .core_result_i(core_result_i),
      .tx_data_o(tx_data), .tx_send_o(tx_send), .tx_busy_i(tx_busy),
      .err_o(frame_err_o)
   );

   mfe_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
      .clk(clk), .rst_n(rst_n), .data_i(tx_data), .send_i(tx_send),
      .busy_o(tx_busy), .tx_o(tx_o)
   );

   assign base_o     = opr[0];
   assign modulus_o  = opr[1];
   assign exponent_o = opr[2];
   assign residue_o  = opr[3];
endmodule

// File: tb/mfe_serial_frontend_tb.sv
`timescale 1ns/1ps
module mfe_serial_frontend_tb;
   localparam int CLK_PERIOD = 20;
   localparam int W    = 32;
   localparam int NB   = W / 8;
   localparam int CPB  = 16;
   localparam int DLY  = 400;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx = 1'b1;
   logic tx;
   logic [W-1:0] base, modulus, exponent, residue, core_result;
   logic core_start, frame_err;
   logic core_done;

   always #(CLK_PERIOD/2) clk = ~clk;

   mfe_serial_frontend #(.CLK_HZ(1_843_200), .BAUD(115_200), .OPERAND_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .rx_i(rx), .tx_o(tx),
      .base_o(base), .modulus_o(modulus), .exponent_o(exponent), .residue_o(residue),
      .core_start_o(core_start), .core_done_i(core_done), .core_result_i(core_result),
      .frame_err_o(frame_err)
   );

   // stub arithmetic core: result = base + exponent after DLY clocks
   int stub_cnt;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stub_cnt <= 0; core_done <= 1'b0; core_result <= '0;
      end else begin
         core_done <= (stub_cnt == 1);
         if (core_start) begin
            stub_cnt    <= DLY;
            core_result <= base + exponent;
         end else if (stub_cnt != 0) stub_cnt <= stub_cnt - 1;
      end
   end

   int checks = 0, fails = 0;
   bit settled = 1'b0;

   // behavioural reference model
   logic [W-1:0] mdl [4];
   logic [W-1:0] mres;
   bit  merr;
   int  mstate;   // 0 command, 1 loading, 2 computing, 3 sending
   int  mslot, mcnt;
   int  starts_seen = 0, starts_exp = 0;
   byte unsigned txq[$];

   task automatic check(input bit ok, input string req, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   task automatic model_byte(input logic [7:0] b, input bit good);
      if (!good) begin merr = 1'b1; return; end
      case (mstate)
         0: begin
            if (b <= 8'h03) begin mstate = 1; mslot = int'(b); mcnt = 0; end
            else if (b == 8'h04) begin mstate = 2; starts_exp++; end
            else if (b == 8'h05) mstate = 3;
            else if (b == 8'h07) merr = 1'b0;
         end
         1: begin
            mdl[mslot] = {b, mdl[mslot][W-1:8]};
            mcnt++;
            if (mcnt == NB) mstate = 0;
         end
         default: ;
      endcase
   endtask

   task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop);
      logic p;
      settled = 1'b0;
      p = (~^d) ^ bad_par;
      @(negedge clk); rx = 1'b0; repeat (CPB) @(negedge clk);
      for (int i = 0; i < 8; i++) begin rx = d[i]; repeat (CPB) @(negedge clk); end
      rx = p; repeat (CPB) @(negedge clk);
      if (bad_stop) begin
         rx = 1'b0; repeat (CPB*3/4) @(negedge clk);
         rx = 1'b1; repeat (CPB/4) @(negedge clk);
      end else begin
         rx = 1'b1; repeat (CPB) @(negedge clk);
      end
      repeat (CPB) @(negedge clk);
      model_byte(d, !bad_par && !bad_stop);
      settled = 1'b1;
   endtask

   // per-clock comparison against the model (R4 R5 R9 R10)
   always @(negedge clk) begin
      if (rst_n && core_start) starts_seen++;
      if (rst_n && settled) begin
         check(base === mdl[0],     "R4", "base",     base,     mdl[0]);
         check(modulus === mdl[1],  "R4", "modulus",  modulus,  mdl[1]);
         check(exponent === mdl[2], "R4", "exponent", exponent, mdl[2]);
         check(residue === mdl[3],  "R4", "residue",  residue,  mdl[3]);
         check(frame_err === merr,  "R9", "frame_err", W'(frame_err), W'(merr));
      end
   end

   // transmit-line decoder (R7)
   initial begin
      @(posedge rst_n);
      forever begin
         logic [7:0] d; logic p;
         @(negedge tx);
         repeat (CPB/2) @(negedge clk);
         check(tx == 1'b0, "R7", "tx start bit", W'(tx), W'(0));
         for (int i = 0; i < 8; i++) begin repeat (CPB) @(negedge clk); d[i] = tx; end
         repeat (CPB) @(negedge clk); p = tx;
         check(^{d, p} == 1'b1, "R7", "tx odd parity", W'({d, p}), W'(0));
         repeat (CPB) @(negedge clk);
         check(tx == 1'b1, "R7", "tx stop bit", W'(tx), W'(1));
         txq.push_back(d);
      end
   end

   task automatic expect_readout(input logic [W-1:0] exp);
      logic [W-1:0] got;
      wait (txq.size() == NB);
      repeat (2*CPB) @(negedge clk);
      got = '0;
      for (int i = 0; i < NB; i++) got[i*8 +: 8] = txq[i];
      check(got === exp, "R7", "readout LSB byte first", got, exp);
      txq.delete();
      mstate = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 4; i++) mdl[i] = '0;
      merr = 1'b0; mstate = 0; mslot = 0; mcnt = 0; mres = '0;
      repeat (5) @(negedge clk);
      // R10: reset state
      check(tx === 1'b1 && core_start === 1'b0 && frame_err === 1'b0, "R10",
            "reset outputs", W'({tx, core_start, frame_err}), W'(3'b100));
      check({base, modulus, exponent, residue} === '0, "R10", "reset operands",
            base | modulus | exponent | residue, '0);
      rst_n = 1'b1;
      settled = 1'b1;
      repeat (CPB) @(negedge clk);

      // R1 R4 R5: load base, first byte ends at the bottom
      send_frame(8'h00, 0, 0);
      send_frame(8'h11, 0, 0); send_frame(8'h22, 0, 0);
      send_frame(8'h33, 0, 0); send_frame(8'h44, 0, 0);
      check(base === 32'h4433_2211, "R4", "base after load", base, 32'h4433_2211);
      // R4: exponent load leaves base alone
      send_frame(8'h02, 0, 0);
      send_frame(8'h05, 0, 0); send_frame(8'hA0, 0, 0);
      send_frame(8'h00, 0, 0); send_frame(8'h01, 0, 0);
      check(exponent === 32'h0100_A005, "R4", "exponent after load", exponent, 32'h0100_A005);
      // R8: unknown opcodes ignored, still in command wait
      send_frame(8'h09, 0, 0); send_frame(8'h06, 0, 0); send_frame(8'hFF, 0, 0);
      // R2 R9: bad parity byte inside a load is dropped and not counted
      send_frame(8'h01, 0, 0);
      send_frame(8'hDE, 0, 0);
      send_frame(8'h77, 1, 0);
      check(frame_err === 1'b1, "R2", "parity error flag", W'(frame_err), W'(1));
      send_frame(8'hAD, 0, 0); send_frame(8'hBE, 0, 0); send_frame(8'hEF, 0, 0);
      check(modulus === 32'hEFBE_ADDE, "R9", "dropped byte not counted", modulus, 32'hEFBE_ADDE);
      // R8: clear, then R3: low stop bit
      send_frame(8'h07, 0, 0);
      check(frame_err === 1'b0, "R8", "clear opcode", W'(frame_err), W'(0));
      send_frame(8'h03, 0, 1);
      check(frame_err === 1'b1, "R3", "stop error flag", W'(frame_err), W'(1));
      send_frame(8'h07, 0, 0);
      // R4: residue load
      send_frame(8'h03, 0, 0);
      send_frame(8'h10, 0, 0); send_frame(8'h20, 0, 0);
      send_frame(8'h30, 0, 0); send_frame(8'h40, 0, 0);
      // R6: run, and a byte during compute is ignored
      send_frame(8'h04, 0, 0);
      send_frame(8'h00, 0, 0);
      wait (core_done === 1'b1);
      @(negedge clk);
      mres = mdl[0] + mdl[2];
      mstate = 0;
      check(starts_seen == starts_exp, "R6", "one start pulse", W'(starts_seen), W'(starts_exp));
      // R7: readout, with a byte sent during transmission ignored
      send_frame(8'h05, 0, 0);
      send_frame(8'h02, 0, 0);
      expect_readout(mres);
      // R7: second readout repeats the same bytes
      send_frame(8'h05, 0, 0);
      expect_readout(mres);
      // R5: opcode values inside a load are data
      send_frame(8'h00, 0, 0);
      send_frame(8'h04, 0, 0); send_frame(8'h05, 0, 0);
      send_frame(8'h07, 0, 0); send_frame(8'h00, 0, 0);
      check(base === 32'h0007_0504, "R5", "opcodes as data", base, 32'h0007_0504);
      check(starts_seen == starts_exp, "R6", "no extra start", W'(starts_seen), W'(starts_exp));
      // R5: command wait again after the load
      send_frame(8'h02, 0, 0);
      send_frame(8'h01, 0, 0); send_frame(8'h02, 0, 0);
      send_frame(8'h03, 0, 0); send_frame(8'h04, 0, 0);
      check(exponent === 32'h0403_0201, "R5", "next load decoded", exponent, 32'h0403_0201);
      repeat (CPB) @(negedge clk);
      finish_run();
   end
endmodule